// File: doc/BRIEF.md
# Fully Associative LRU Tag Store with Nested-Size Hit Tracking

This block holds the tags of a fully associative cache and keeps every block in a strict recency order, from most recently used to least recently used. Each lookup returns hit or miss and the index of the hit block. It also returns a size mask that tells which smaller power-of-two caches would have hit on the same access. One recency order therefore stands in for a whole family of nested cache sizes. Capacity studies can read the miss rate of every smaller size from one instance.

Recency is held as an age rank per block, with 0 the most recent and NUM_BLKS-1 the least recent. The tracked sizes are MIN_BLKS, 2*MIN_BLKS and so on, doubling up to NUM_BLKS/2 blocks. Bit k of a block's mask is set when its rank is below MIN_BLKS<<k. A fill always replaces the least-recent block. Invalidation is by address and leaves the recency order untouched. The block keeps counters for accesses, hits and misses per size, and replacements, plus an in-use count and a warm-up flag.

Top module: `nested_lru_tagstore`

## Requirements
- R1: After reset all blocks are invalid, block i has rank i, so the victim index is NUM_BLKS-1. All counters, the in-use count, the warm flag and the response valid are 0.
- R2: Lookup, fill and invalidate addresses are compared on the tag only. The tag is the address with its low log2(BLK_BYTES) bits removed, so addresses that differ only in those bits refer to the same block. At most one valid block matches any tag.
- R3: An accepted lookup produces rsp_vld_o exactly HIT_LAT cycles later, with rsp_hit_o, rsp_idx_o and rsp_mask_o. Bit k of the mask is set when the hit block's rank before the access is below MIN_BLKS<<k. On a miss the index and the mask are 0.
- R4: A hit moves the block to rank 0. Every block whose rank was below the old rank of the hit block moves down by one. All other ranks stay as they were.
- R5: On a hit, each tracked size k counts a hit in hit slot k if mask bit k is set, and a miss in miss slot k if it is not. Slot NUM_SZ is the full-size slot, and it counts a hit. Slot k sits at bits [k*CNT_W +: CNT_W].
- R6: On a miss every slot, 0 to NUM_SZ, counts a miss, and no rank changes.
- R7: The access counter increments once for every accepted lookup.
- R8: A fill retags the least-recent block (rank NUM_BLKS-1) with the new tag, marks it valid and moves it to rank 0. victim_idx_o always shows the block that the next fill will take.
- R9: A fill into an invalid block increments the in-use count. A fill over a valid block increments the replacement counter instead. The in-use count never exceeds NUM_BLKS.
- R10: The warm flag sets in the cycle the in-use count reaches NUM_BLKS. It stays set until reset.
- R11: An invalidate whose tag matches a valid block clears that block's valid state and decrements the in-use count. It leaves all ranks unchanged. An invalidate that matches no block changes nothing.
- R12: When a fill is requested, any lookup or invalidate in the same cycle is ignored. Such a lookup gives no response and changes no counter.
- R13: A lookup and an invalidate in the same cycle are both performed. The lookup sees the valid state from before the invalidate. Both act on the block if they name the same tag.
- R14: A hit mask is nested: if bit k is set, every bit above k is set too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_vld_i | input | 1 | Lookup request |
| lkp_addr_i | input | ADDR_W | Lookup address |
| fill_vld_i | input | 1 | Fill request (address must not be present) |
| fill_addr_i | input | ADDR_W | Fill address |
| inv_vld_i | input | 1 | Invalidate request |
| inv_addr_i | input | ADDR_W | Invalidate address |
| rsp_vld_o | output | 1 | Lookup response valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_idx_o | output | IDX_W | Hit block index |
| rsp_mask_o | output | NUM_SZ | Per-size hit mask |
| victim_idx_o | output | IDX_W | Block the next fill replaces |
| warm_o | output | 1 | All blocks have been filled once |
| inuse_o | output | IDX_W+1 | Number of valid blocks |
| acc_cnt_o | output | CNT_W | Accepted lookups |
| hit_cnt_o | output | (NUM_SZ+1)*CNT_W | Hit counters per size, full size on top |
| miss_cnt_o | output | (NUM_SZ+1)*CNT_W | Miss counters per size, full size on top |
| repl_cnt_o | output | CNT_W | Fills over valid blocks |

## Verification
A lookup and an invalidate can land in the same cycle. The lookup must still see the valid state from before the invalidate, promote the block and count a hit, while the block is cleared at the same edge. The bench forces this on one tag in a directed step and then issues a lookup on that tag, which must miss. Random traffic also pairs the two freely. Every response, counter, victim index and in-use value is judged against a bench model that applies the lookup to the old state before the invalidate.

// File: rtl/nlt_pkg.sv
package nlt_pkg;
   // true when v is a positive power of two
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/nlt_tag_array.sv
module nlt_tag_array #(
   parameter int NUM_BLKS = 16,
   parameter int TAG_W    = 28,
   localparam int IDX_W   = $clog2(NUM_BLKS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [TAG_W-1:0]    wr_tag,
   input  logic                clr_en,
   input  logic [IDX_W-1:0]    clr_idx,
   input  logic [TAG_W-1:0]    lkp_tag,
   input  logic [TAG_W-1:0]    inv_tag,
   output logic [NUM_BLKS-1:0] vld_o,
   output logic [NUM_BLKS-1:0] lkp_match_o,
   output logic [NUM_BLKS-1:0] inv_match_o
);
   logic [NUM_BLKS-1:0][TAG_W-1:0] tag_q;
   logic [NUM_BLKS-1:0]            vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         tag_q <= '0;
      end else begin
         for (int i = 0; i < NUM_BLKS; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
               vld_q[i] <= 1'b1;
               tag_q[i] <= wr_tag;
            end else if (clr_en && clr_idx == IDX_W'(i)) begin
               vld_q[i] <= 1'b0;
            end
         end
      end
   end

   for (genvar gi = 0; gi < NUM_BLKS; gi++) begin : g_cmp
      assign lkp_match_o[gi] = vld_q[gi] && (tag_q[gi] == lkp_tag);
      assign inv_match_o[gi] = vld_q[gi] && (tag_q[gi] == inv_tag);
   end

   assign vld_o = vld_q;
endmodule

// File: rtl/nlt_recency.sv
module nlt_recency #(
   parameter int NUM_BLKS = 16,
   parameter int MIN_BLKS = 2,
   localparam int IDX_W   = $clog2(NUM_BLKS),
   localparam int NUM_SZ  = $clog2(NUM_BLKS) - $clog2(MIN_BLKS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             touch_en,
   input  logic [IDX_W-1:0]                 touch_idx,
   output logic [NUM_BLKS-1:0][IDX_W-1:0]   rank_o,
   output logic [NUM_BLKS-1:0][NUM_SZ-1:0]  mask_o,
   output logic [IDX_W-1:0]                 victim_o
);
   logic [NUM_BLKS-1:0][IDX_W-1:0] rank_q;
   logic [IDX_W-1:0]               touch_rank;

   assign touch_rank = rank_q[touch_idx];

   // promote the touched block, age the younger ones
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_BLKS; i++) rank_q[i] <= IDX_W'(i);
      end else if (touch_en) begin
         for (int i = 0; i < NUM_BLKS; i++) begin
            if (touch_idx == IDX_W'(i))     rank_q[i] <= '0;
            else if (rank_q[i] < touch_rank) rank_q[i] <= rank_q[i] + 1'b1;
         end
      end
   end

   // size bit k: rank inside the MIN_BLKS<<k youngest positions
   for (genvar gi = 0; gi < NUM_BLKS; gi++) begin : g_blk
      for (genvar gk = 0; gk < NUM_SZ; gk++) begin : g_sz
         assign mask_o[gi][gk] = (rank_q[gi] < IDX_W'(MIN_BLKS << gk));
      end
   end

   always_comb begin
      victim_o = '0;
      for (int i = 0; i < NUM_BLKS; i++)
         if (rank_q[i] == IDX_W'(NUM_BLKS - 1)) victim_o = IDX_W'(i);
   end

   assign rank_o = rank_q;
endmodule

// File: rtl/nlt_stats.sv
module nlt_stats #(
   parameter int NUM_SZ = 3,
   parameter int CNT_W  = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        acc_en,
   input  logic                        hit,
   input  logic [NUM_SZ-1:0]           hmask,
   input  logic                        repl_en,
   output logic [CNT_W-1:0]            acc_o,
   output logic [(NUM_SZ+1)*CNT_W-1:0] hit_o,
   output logic [(NUM_SZ+1)*CNT_W-1:0] miss_o,
   output logic [CNT_W-1:0]            repl_o
);
   logic [CNT_W-1:0] acc_q, repl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         repl_q <= '0;
      end else begin
         if (acc_en)  acc_q  <= acc_q + 1'b1;
         if (repl_en) repl_q <= repl_q + 1'b1;
      end
   end

   for (genvar gk = 0; gk <= NUM_SZ; gk++) begin : g_slot
      logic             sz_hit;
      logic [CNT_W-1:0] hit_q, miss_q;
      if (gk < NUM_SZ) begin : g_part
         assign sz_hit = hit && hmask[gk];
      end else begin : g_full
         assign sz_hit = hit;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hit_q  <= '0;
            miss_q <= '0;
         end else if (acc_en) begin
            if (sz_hit) hit_q  <= hit_q + 1'b1;
            else        miss_q <= miss_q + 1'b1;
         end
      end
      assign hit_o[gk*CNT_W +: CNT_W]  = hit_q;
      assign miss_o[gk*CNT_W +: CNT_W] = miss_q;
   end

   assign acc_o  = acc_q;
   assign repl_o = repl_q;
endmodule

// File: rtl/nlt_rsp_pipe.sv
module nlt_rsp_pipe #(
   parameter int LAT = 1,
   parameter int W   = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [W-1:0] in_data,
   output logic         out_vld,
   output logic [W-1:0] out_data
);
   if (LAT == 1) begin : g_single
      logic         v_q;
      logic [W-1:0] d_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else begin
            v_q <= in_vld;
            d_q <= in_data;
         end
      end
      assign out_vld  = v_q;
      assign out_data = d_q;
   end else begin : g_chain
      logic [LAT-1:0]        v_q;
      logic [LAT-1:0][W-1:0] d_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= '0;
            d_q <= '0;
         end else begin
            v_q[0] <= in_vld;
            d_q[0] <= in_data;
            for (int s = 1; s < LAT; s++) begin
               v_q[s] <= v_q[s-1];
               d_q[s] <= d_q[s-1];
            end
         end
      end
      assign out_vld  = v_q[LAT-1];
      assign out_data = d_q[LAT-1];
   end
endmodule

// File: rtl/nested_lru_tagstore.sv
module nested_lru_tagstore #(
   parameter int ADDR_W    = 32,
   parameter int BLK_BYTES = 16,
   parameter int NUM_BLKS  = 16,
   parameter int MIN_BLKS  = 2,
   parameter int HIT_LAT   = 1,
   parameter int CNT_W     = 16,
   localparam int OFF_W    = $clog2(BLK_BYTES),
   localparam int TAG_W    = ADDR_W - OFF_W,
   localparam int IDX_W    = $clog2(NUM_BLKS),
   localparam int NUM_SZ   = $clog2(NUM_BLKS) - $clog2(MIN_BLKS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        lkp_vld_i,
   input  logic [ADDR_W-1:0]           lkp_addr_i,
   input  logic                        fill_vld_i,
   input  logic [ADDR_W-1:0]           fill_addr_i,
   input  logic                        inv_vld_i,
   input  logic [ADDR_W-1:0]           inv_addr_i,
   output logic                        rsp_vld_o,
   output logic                        rsp_hit_o,
   output logic [IDX_W-1:0]            rsp_idx_o,
   output logic [NUM_SZ-1:0]           rsp_mask_o,
   output logic [IDX_W-1:0]            victim_idx_o,
   output logic                        warm_o,
   output logic [IDX_W:0]              inuse_o,
   output logic [CNT_W-1:0]            acc_cnt_o,
   output logic [(NUM_SZ+1)*CNT_W-1:0] hit_cnt_o,
   output logic [(NUM_SZ+1)*CNT_W-1:0] miss_cnt_o,
   output logic [CNT_W-1:0]            repl_cnt_o
);
   import nlt_pkg::*;

   localparam int RSP_W = 1 + IDX_W + NUM_SZ;

   // elaboration-time parameter checks
   if (!is_pow2(BLK_BYTES)) begin : g_bad_blk
      $error("BLK_BYTES must be a power of two");
   end
   if (!is_pow2(NUM_BLKS) || NUM_BLKS < 4) begin : g_bad_num
      $error("NUM_BLKS must be a power of two, at least 4");
   end
   if (!is_pow2(MIN_BLKS) || MIN_BLKS >= NUM_BLKS) begin : g_bad_min
      $error("MIN_BLKS must be a power of two below NUM_BLKS");
   end
   if (HIT_LAT < 1) begin : g_bad_lat
      $error("HIT_LAT must be at least one cycle");
   end
   if (OFF_W >= ADDR_W) begin : g_bad_addr
      $error("ADDR_W too small for BLK_BYTES");
   end

   // request arbitration: a fill owns the cycle
   logic fill_go, lkp_go, inv_go;
   assign fill_go = fill_vld_i;
   assign lkp_go  = lkp_vld_i && !fill_vld_i;
   assign inv_go  = inv_vld_i && !fill_vld_i;

   logic [NUM_BLKS-1:0]             vld_w, lkp_match, inv_match;
   logic [NUM_BLKS-1:0][IDX_W-1:0]  rank_w;
   logic [NUM_BLKS-1:0][NUM_SZ-1:0] mask_w;
   logic [IDX_W-1:0]                victim_w, hit_idx, inv_idx;
   logic                            lkp_hit, inv_hit;
   logic [NUM_SZ-1:0]               hmask;

   nlt_tag_array #(.NUM_BLKS(NUM_BLKS), .TAG_W(TAG_W)) u_tags (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (fill_go),
      .wr_idx      (victim_w),
      .wr_tag      (fill_addr_i[ADDR_W-1:OFF_W]),
      .clr_en      (inv_go && inv_hit),
      .clr_idx     (inv_idx),
      .lkp_tag     (lkp_addr_i[ADDR_W-1:OFF_W]),
      .inv_tag     (inv_addr_i[ADDR_W-1:OFF_W]),
      .vld_o       (vld_w),
      .lkp_match_o (lkp_match),
      .inv_match_o (inv_match)
   );

   // one-hot to index; tags are unique among valid blocks
   always_comb begin
      hit_idx = '0;
      inv_idx = '0;
      for (int i = 0; i < NUM_BLKS; i++) begin
         if (lkp_match[i]) hit_idx = hit_idx | IDX_W'(i);
         if (inv_match[i]) inv_idx = inv_idx | IDX_W'(i);
      end
   end
   assign lkp_hit = |lkp_match;
   assign inv_hit = |inv_match;
   assign hmask   = lkp_hit ? mask_w[hit_idx] : '0;

   nlt_recency #(.NUM_BLKS(NUM_BLKS), .MIN_BLKS(MIN_BLKS)) u_rank (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  (fill_go || (lkp_go && lkp_hit)),
      .touch_idx (fill_go ? victim_w : hit_idx),
      .rank_o    (rank_w),
      .mask_o    (mask_w),
      .victim_o  (victim_w)
   );

   // occupancy and warm-up
   logic [IDX_W:0] inuse_q, inuse_nxt;
   logic           warm_q;
   always_comb begin
      inuse_nxt = inuse_q;
      if (fill_go && !vld_w[victim_w]) inuse_nxt = inuse_q + 1'b1;
      else if (inv_go && inv_hit)      inuse_nxt = inuse_q - 1'b1;
   end
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inuse_q <= '0;
         warm_q  <= 1'b0;
      end else begin
         inuse_q <= inuse_nxt;
         if (inuse_nxt == (IDX_W+1)'(NUM_BLKS)) warm_q <= 1'b1;
      end
   end
   assign inuse_o = inuse_q;
   assign warm_o  = warm_q;

   nlt_stats #(.NUM_SZ(NUM_SZ), .CNT_W(CNT_W)) u_stats (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_en  (lkp_go),
      .hit     (lkp_hit),
      .hmask   (hmask),
      .repl_en (fill_go && vld_w[victim_w]),
      .acc_o   (acc_cnt_o),
      .hit_o   (hit_cnt_o),
      .miss_o  (miss_cnt_o),
      .repl_o  (repl_cnt_o)
   );

   logic [RSP_W-1:0] rsp_d;
   nlt_rsp_pipe #(.LAT(HIT_LAT), .W(RSP_W)) u_rsp (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (lkp_go),
      .in_data  ({lkp_hit, (lkp_hit ? hit_idx : IDX_W'(0)), hmask}),
      .out_vld  (rsp_vld_o),
      .out_data (rsp_d)
   );
   assign {rsp_hit_o, rsp_idx_o, rsp_mask_o} = rsp_d;
   assign victim_idx_o = victim_w;
endmodule

// File: rtl/nlt_chk.sv
module nlt_chk #(
   parameter int NUM_BLKS = 16,
   parameter int MIN_BLKS = 2,
   parameter int CNT_W    = 16,
   localparam int IDX_W   = $clog2(NUM_BLKS),
   localparam int NUM_SZ  = $clog2(NUM_BLKS) - $clog2(MIN_BLKS)
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           fill_vld_i,
   input logic                           fill_go,
   input logic                           lkp_go,
   input logic [NUM_BLKS-1:0]            lkp_match,
   input logic [NUM_BLKS-1:0]            vld_w,
   input logic [NUM_BLKS-1:0][IDX_W-1:0] rank_w,
   input logic [IDX_W-1:0]               victim_w,
   input logic                           rsp_vld_o,
   input logic                           rsp_hit_o,
   input logic [NUM_SZ-1:0]              rsp_mask_o,
   input logic                           warm_o,
   input logic [IDX_W:0]                 inuse_o,
   input logic [CNT_W-1:0]               acc_cnt_o
);
   // R2
   unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lkp_match));

   // R8
   fill_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_go |=> (rank_w[$past(victim_w)] == '0) && vld_w[$past(victim_w)]);

   // R6
   miss_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lkp_go && !(|lkp_match)) |=> (rank_w == $past(rank_w)));

   // R14
   mask_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld_o && rsp_hit_o) |-> ((NUM_SZ'(rsp_mask_o << 1) & ~rsp_mask_o) == '0));

   // R10
   warm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      warm_o |=> warm_o);

   // R9
   inuse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inuse_o <= (IDX_W+1)'(NUM_BLKS));

   // R7
   acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lkp_go |=> (acc_cnt_o == $past(acc_cnt_o) + 1'b1));

   // R12
   fill_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_vld_i |=> (acc_cnt_o == $past(acc_cnt_o)));
endmodule

bind nested_lru_tagstore nlt_chk #(
   .NUM_BLKS (NUM_BLKS),
   .MIN_BLKS (MIN_BLKS),
   .CNT_W    (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fill_vld_i (fill_vld_i),
   .fill_go    (fill_go),
   .lkp_go     (lkp_go),
   .lkp_match  (lkp_match),
   .vld_w      (vld_w),
   .rank_w     (rank_w),
   .victim_w   (victim_w),
   .rsp_vld_o  (rsp_vld_o),
   .rsp_hit_o  (rsp_hit_o),
   .rsp_mask_o (rsp_mask_o),
   .warm_o     (warm_o),
   .inuse_o    (inuse_o),
   .acc_cnt_o  (acc_cnt_o)
);

// File: tb/tb_nested_lru_tagstore.sv
module tb_nested_lru_tagstore;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 32;
   localparam int BB   = 16;
   localparam int NB   = 16;
   localparam int MINB = 2;
   localparam int NS   = 3;
   localparam int CW   = 16;
   localparam int IW   = 4;

   logic clk = 0, rst_n = 0;
   logic lkp_vld = 0, fill_vld = 0, inv_vld = 0;
   logic [AW-1:0] lkp_addr = '0, fill_addr = '0, inv_addr = '0;
   logic rsp_vld, rsp_hit, warm;
   logic [IW-1:0] rsp_idx, victim;
   logic [NS-1:0] rsp_mask;
   logic [IW:0] inuse;
   logic [CW-1:0] acc_cnt, repl_cnt;
   logic [(NS+1)*CW-1:0] hit_cnt, miss_cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   nested_lru_tagstore #(.ADDR_W(AW), .BLK_BYTES(BB), .NUM_BLKS(NB), .MIN_BLKS(MINB),
                         .HIT_LAT(1), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n),
      .lkp_vld_i(lkp_vld), .lkp_addr_i(lkp_addr),
      .fill_vld_i(fill_vld), .fill_addr_i(fill_addr),
      .inv_vld_i(inv_vld), .inv_addr_i(inv_addr),
      .rsp_vld_o(rsp_vld), .rsp_hit_o(rsp_hit), .rsp_idx_o(rsp_idx), .rsp_mask_o(rsp_mask),
      .victim_idx_o(victim), .warm_o(warm), .inuse_o(inuse),
      .acc_cnt_o(acc_cnt), .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt), .repl_cnt_o(repl_cnt)
   );

   // reference model
   int m_tag[NB];
   bit m_vld[NB];
   int m_rank[NB];
   int m_hit[NS+1], m_miss[NS+1];
   int m_acc, m_repl, m_inuse;
   bit m_warm;
   bit e_rvld, e_hit;
   int e_idx, e_mask;
   int checks = 0, errors = 0;
   bit done = 0;

   task automatic chk(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int find_tag(int t);
      for (int i = 0; i < NB; i++) if (m_vld[i] && m_tag[i] == t) return i;
      return -1;
   endfunction

   function automatic int mask_of(int b);
      int m = 0;
      for (int k = 0; k < NS; k++) if (m_rank[b] < (MINB << k)) m |= (1 << k);
      return m;
   endfunction

   function automatic int m_victim();
      for (int i = 0; i < NB; i++) if (m_rank[i] == NB-1) return i;
      return 0;
   endfunction

   function automatic void promote(int b);
      int r = m_rank[b];
      for (int i = 0; i < NB; i++) if (m_rank[i] < r) m_rank[i]++;
      m_rank[b] = 0;
   endfunction

   function automatic void model_reset();
      for (int i = 0; i < NB; i++) begin
         m_tag[i] = 0; m_vld[i] = 0; m_rank[i] = i;
      end
      for (int k = 0; k <= NS; k++) begin m_hit[k] = 0; m_miss[k] = 0; end
      m_acc = 0; m_repl = 0; m_inuse = 0; m_warm = 0; e_rvld = 0; e_hit = 0; e_idx = 0; e_mask = 0;
   endfunction

   // R12, R13: fill owns the cycle; lookup sees state before invalidate
   function automatic void model_step(bit lv, int la, bit fv, int fa, bit iv, int ia);
      bit lgo = lv && !fv;
      bit igo = iv && !fv;
      int h, j, v;
      e_rvld = lgo; e_hit = 0; e_idx = 0; e_mask = 0;
      j = igo ? find_tag(ia / BB) : -1;
      if (lgo) begin
         m_acc++;
         h = find_tag(la / BB);
         if (h >= 0) begin
            e_hit = 1; e_idx = h; e_mask = mask_of(h);
            for (int k = 0; k < NS; k++)
               if (e_mask[k]) m_hit[k]++; else m_miss[k]++;
            m_hit[NS]++;
            promote(h);
         end else begin
            for (int k = 0; k <= NS; k++) m_miss[k]++;
         end
      end
      if (j >= 0) begin
         m_vld[j] = 0; m_inuse--;
      end
      if (fv) begin
         v = m_victim();
         if (m_vld[v]) m_repl++; else m_inuse++;
         m_vld[v] = 1; m_tag[v] = fa / BB;
         promote(v);
      end
      if (m_inuse == NB) m_warm = 1;
   endfunction

   task automatic compare_all();
      chk("R3 rsp_vld", rsp_vld, e_rvld);
      if (e_rvld) begin
         chk("R3 rsp_hit", rsp_hit, e_hit);
         chk("R3 rsp_idx", rsp_idx, e_idx);
         chk("R3 rsp_mask", rsp_mask, e_mask);
      end
      chk("R8 victim_idx", victim, m_victim());
      chk("R10 warm", warm, m_warm);
      chk("R9 inuse", inuse, m_inuse);
      chk("R7 acc_cnt", acc_cnt, m_acc);
      chk("R9 repl_cnt", repl_cnt, m_repl);
      for (int k = 0; k <= NS; k++) begin
         chk("R5 hit_cnt slot", hit_cnt[k*CW +: CW], m_hit[k]);
         chk("R6 miss_cnt slot", miss_cnt[k*CW +: CW], m_miss[k]);
      end
   endtask

   // drive after a falling edge, judge at the next falling edge
   task automatic step(bit lv, int la, bit fv, int fa, bit iv, int ia);
      lkp_vld = lv; lkp_addr = AW'(la);
      fill_vld = fv; fill_addr = AW'(fa);
      inv_vld = iv; inv_addr = AW'(ia);
      model_step(lv, la, fv, fa, iv, ia);
      @(negedge clk);
      lkp_vld = 0; fill_vld = 0; inv_vld = 0;
      compare_all();
   endtask

   initial begin
      void'($urandom(32'h1C0FFEE));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 victim", victim, NB-1);
      chk("R1 inuse", inuse, 0);
      chk("R1 warm", warm, 0);
      chk("R1 rsp_vld", rsp_vld, 0);
      chk("R1 acc_cnt", acc_cnt, 0);
      chk("R1 hit_cnt", hit_cnt, 0);
      chk("R1 miss_cnt", miss_cnt, 0);
      // R6 cold miss
      step(1, 'h50, 0, 0, 0, 0);
      // R8 R9 R10 fill every block, offsets vary
      for (int b = 0; b < NB; b++) step(0, 0, 1, b*BB + (b % BB), 0, 0);
      chk("R10 warm after full", warm, 1);
      // R2 offset ignored, R4 R5 masks by position
      step(1, 3*BB + 15, 0, 0, 0, 0);
      chk("R2 offset hit", rsp_hit, 1);
      step(1, 15*BB, 0, 0, 0, 0);
      chk("R5 youngest mask", rsp_mask, 7);
      step(1, 15*BB + 1, 0, 0, 0, 0);
      // R12 fill with lookup and invalidate: both ignored
      step(1, 5*BB, 1, 20*BB, 1, 6*BB);
      chk("R12 no rsp", rsp_vld, 0);
      // R13 lookup and invalidate of the same tag
      step(1, 15*BB, 0, 0, 1, 15*BB + 2);
      chk("R13 hit old state", rsp_hit, 1);
      step(1, 15*BB, 0, 0, 0, 0);
      chk("R13 gone after", rsp_hit, 0);
      // R11 invalidate of absent tag
      step(0, 0, 0, 0, 1, 30*BB);
      chk("R11 absent inv", inuse, NB-1);
      // R10 stays after invalidates
      chk("R10 sticky", warm, 1);
      // random mix
      for (int n = 0; n < 4000; n++) begin
         int op = $urandom_range(0, 9);
         int la = $urandom_range(0, 23)*BB + $urandom_range(0, BB-1);
         int fa = $urandom_range(0, 23)*BB + $urandom_range(0, BB-1);
         int ia = $urandom_range(0, 23)*BB + $urandom_range(0, BB-1);
         bit lv = (op < 7);
         bit fv = (op >= 6) && (op <= 7) && (find_tag(fa / BB) < 0);
         bit iv = (op >= 8) || (op == 3);
         step(lv, la, fv, fa, iv, ia);
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule